// File: doc/BRIEF.md
# Two-Row Key Matrix Scanner

This block scans a key matrix of sixteen source lines and two return rows. It drives one source line at a time, holds it for a fixed number of clock cycles, and samples both return rows at the end of that dwell. The sixteen sources are split across two display frames. The first frame of a scan cycle walks sources 1 to 8 and the second walks sources 9 to 16. The display controller marks each frame boundary with a one-cycle `frame_end` pulse.

Results collect in a private shadow register. They reach the visible 32-bit key buffer in a single clock edge, at the frame boundary that closes a complete cycle. The host reads the buffer as a serial bit stream through a small read port. A restart takes a snapshot of the buffer and points at bit 0. Each advance moves to the next bit. The byte that holds the current bit is also presented in parallel.

Scanning runs only while `scan_en` is high, whether or not the display itself is lit. Dropping `scan_en` halts the scan and discards any half-finished cycle. Scanning resumes at the first frame boundary after `scan_en` returns high.

Top module: `keymatrix_scan`

## Requirements
- R1: After reset, `src_drive` is all zeros, every key bit reads 0 (both serially and by byte), and the read position is bit 0.
- R2: At most one bit of `src_drive` is high at any time, and each driven source stays driven for exactly SLOT_CYC (default 4) consecutive cycles.
- R3: A cycle starts only at a `frame_end` pulse seen while `scan_en` is high. The first frame drives sources 1 to 8 in ascending order (`src_drive` bit 0 up to bit 7). The second frame drives sources 9 to 16 (bit 8 up to bit 15). Frames then continue to alternate.
- R4: The result for source s (numbered 1 to 16) on return row `key_ret[0]` goes to stream bit 2(s-1). The result on row `key_ret[1]` goes to stream bit 2(s-1)+1. Byte n of the buffer is stream bits 8n to 8n+7, so byte 0 covers sources 1 to 4 and byte 3 covers sources 13 to 16.
- R5: The key buffer changes only at the `frame_end` that closes the second frame of a cycle. It changes only if both frames finished all eight of their sources before their closing `frame_end`. Otherwise the cycle is dropped and the buffer keeps its old contents.
- R6: While `scan_en` is low, `src_drive` is zero from the next cycle onward and the key buffer holds its value. A partly scanned cycle is discarded.
- R7: `rd_restart` snapshots the key buffer and selects stream bit 0. Each `rd_adv` moves to the next bit, so bit 7 of byte n is followed by bit 0 of byte n+1, and bit 31 wraps to bit 0. `rd_bit` shows the selected bit and `rd_byte` shows the whole byte that contains it.
- R8: A buffer update that lands during a read does not change `rd_bit` or `rd_byte` until the next `rd_restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Scanning allowed while high |
| frame_end | input | 1 | One-cycle pulse at each display frame boundary |
| key_ret | input | N_RET (2) | Return rows; bit 0 is the even-bit row |
| src_drive | output | N_SRC (16) | One-hot key source drive |
| rd_restart | input | 1 | Snapshot the buffer and select bit 0 |
| rd_adv | input | 1 | Advance the read position by one bit |
| rd_bit | output | 1 | Currently selected key bit |
| rd_byte | output | 8 | Byte that contains the selected bit |

## Verification
A wrong source counter or frame half would show up on `src_drive` within one slot: two lines high at once, a dwell of the wrong length, or a source out of order. A wrong index into the shadow register only becomes visible after the next complete two-frame cycle, when a single pressed key reads back at the wrong stream position. A commit-gating error shows up as a changed buffer after frames that were too short, or after `scan_en` was dropped. A snapshot error shows up as a mid-read change in the serial bits.

// File: rtl/kms_pkg.sv
package kms_pkg;

  // Counter width for a range of n values, never narrower than one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Stream bit position of return row ret for zero-based source src.
  function automatic int unsigned key_pos(input int unsigned src,
                                          input int unsigned ret,
                                          input int unsigned n_ret);
    return src * n_ret + ret;
  endfunction

endpackage

// File: rtl/kms_seq.sv
module kms_seq
  import kms_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned SLOT_CYC = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_en,
  input  logic                          frame_end,
  output logic [N_SRC-1:0]              src_drive,
  output logic                          sample_o,
  output logic [cnt_width(N_SRC)-1:0]   sample_src,
  output logic                          commit_o
);
  localparam int unsigned HALF  = N_SRC / 2;
  localparam int unsigned HS_W  = cnt_width(HALF);
  localparam int unsigned SL_W  = cnt_width(SLOT_CYC);
  localparam int unsigned SRC_W = cnt_width(N_SRC);

  logic            armed_q, half_q, busy_q, first_ok_q;
  logic [HS_W-1:0] src_q;
  logic [SL_W-1:0] slot_q;

  logic last_slot, last_src;
  assign last_slot = (slot_q == SL_W'(SLOT_CYC - 1));
  assign last_src  = (src_q == HS_W'(HALF - 1));

  assign sample_src = SRC_W'(src_q) + (half_q ? SRC_W'(HALF) : SRC_W'(0));
  assign sample_o   = armed_q & scan_en & busy_q & last_slot & ~frame_end;
  assign commit_o   = armed_q & scan_en & frame_end & half_q & first_ok_q & ~busy_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_drive
    assign src_drive[i] = busy_q && (sample_src == SRC_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; half_q <= 1'b0; busy_q <= 1'b0; first_ok_q <= 1'b0;
      src_q <= '0; slot_q <= '0;
    end else if (!scan_en) begin
      armed_q <= 1'b0; half_q <= 1'b0; busy_q <= 1'b0; first_ok_q <= 1'b0;
      src_q <= '0; slot_q <= '0;
    end else if (frame_end) begin
      if (!armed_q) begin
        armed_q    <= 1'b1;
        half_q     <= 1'b0;
        first_ok_q <= 1'b0;
      end else begin
        half_q     <= ~half_q;
        first_ok_q <= ~half_q & ~busy_q;
      end
      busy_q <= 1'b1;
      src_q  <= '0;
      slot_q <= '0;
    end else if (busy_q) begin
      if (last_slot) begin
        slot_q <= '0;
        if (last_src) busy_q <= 1'b0;
        else          src_q  <= src_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  // R2
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_drive));

  // R2
  drive_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(src_drive) && (|src_drive) && (|$past(src_drive)) && !$past(frame_end))
      |-> $past(sample_o));

  // R3
  frame_first_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|src_drive) |-> (src_drive[0] || src_drive[HALF]));

  // R6
  halt_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (src_drive == '0));

endmodule

// File: rtl/kms_capture.sv
module kms_capture
  import kms_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned N_RET = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sample_i,
  input  logic [cnt_width(N_SRC)-1:0] sample_src,
  input  logic [N_RET-1:0]            key_ret,
  input  logic                        commit_i,
  output logic [N_SRC*N_RET-1:0]      key_buf
);
  localparam int unsigned KEY_BITS = N_SRC * N_RET;

  logic [KEY_BITS-1:0] shadow_q;
  logic [KEY_BITS-1:0] shadow_d;

  // Each source owns N_RET adjacent bits; only the sampled source is rewritten.
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar r = 0; r < N_RET; r++) begin : g_ret
      localparam int unsigned POS = key_pos(s, r, N_RET);
      assign shadow_d[POS] = (sample_i && (int'(sample_src) == s)) ? key_ret[r]
                                                                    : shadow_q[POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      key_buf  <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (commit_i) key_buf <= shadow_q;
    end
  end

  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(key_buf));

  // R5
  no_sample_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_i && sample_i));

endmodule

// File: rtl/kms_readout.sv
module kms_readout
  import kms_pkg::*;
#(
  parameter int unsigned KEY_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [KEY_BITS-1:0] key_buf,
  input  logic                rd_restart,
  input  logic                rd_adv,
  output logic                rd_bit,
  output logic [7:0]          rd_byte
);
  localparam int unsigned PTR_W = cnt_width(KEY_BITS);

  logic [KEY_BITS-1:0] snap_q;
  logic [PTR_W-1:0]    ptr_q;
  logic                ptr_last;

  assign ptr_last = (ptr_q == PTR_W'(KEY_BITS - 1));
  assign rd_bit   = snap_q[ptr_q];
  assign rd_byte  = snap_q[8 * int'(ptr_q[PTR_W-1:3]) +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      ptr_q  <= '0;
    end else if (rd_restart) begin
      snap_q <= key_buf;
      ptr_q  <= '0;
    end else if (rd_adv) begin
      ptr_q <= ptr_last ? '0 : ptr_q + 1'b1;
    end
  end

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_restart |=> $stable(snap_q));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !rd_restart && ptr_last) |=> (ptr_q == '0));

  // R7
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_adv && !rd_restart) |=> $stable(rd_bit) && $stable(rd_byte));

endmodule

// File: rtl/keymatrix_scan.sv
module keymatrix_scan
  import kms_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned N_RET    = 2,
  parameter int unsigned SLOT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             frame_end,
  input  logic [N_RET-1:0] key_ret,
  output logic [N_SRC-1:0] src_drive,
  input  logic             rd_restart,
  input  logic             rd_adv,
  output logic             rd_bit,
  output logic [7:0]       rd_byte
);
  localparam int unsigned KEY_BITS = N_SRC * N_RET;
  localparam int unsigned SRC_W    = cnt_width(N_SRC);

  logic             sample_w;
  logic             commit_w;
  logic [SRC_W-1:0] sample_src_w;
  logic [KEY_BITS-1:0] key_buf_w;

  kms_seq #(.N_SRC(N_SRC), .SLOT_CYC(SLOT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .frame_end(frame_end),
    .src_drive(src_drive), .sample_o(sample_w), .sample_src(sample_src_w),
    .commit_o(commit_w)
  );

  kms_capture #(.N_SRC(N_SRC), .N_RET(N_RET)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_w), .sample_src(sample_src_w),
    .key_ret(key_ret), .commit_i(commit_w), .key_buf(key_buf_w)
  );

  kms_readout #(.KEY_BITS(KEY_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .key_buf(key_buf_w), .rd_restart(rd_restart),
    .rd_adv(rd_adv), .rd_bit(rd_bit), .rd_byte(rd_byte)
  );

  // R5
  commit_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(key_buf_w));

endmodule

// File: tb/keymatrix_scan_bench.sv
module keymatrix_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 4;
  localparam int FRAME_OK = 40;
  localparam int FRAME_SHORT = 20;

  logic clk = 0, rst_n = 0, scan_en = 0, frame_end = 0;
  logic rd_restart = 0, rd_adv = 0;
  logic [1:0]  key_ret;
  logic [15:0] src_drive;
  logic        rd_bit;
  logic [7:0]  rd_byte;
  logic [15:0] keys_a = '0, keys_b = '0;
  int frame_len = FRAME_OK;
  int fcnt = 0;
  int total = 0, bad = 0, multi_hot = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign key_ret[0] = |(src_drive & keys_a);
  assign key_ret[1] = |(src_drive & keys_b);

  keymatrix_scan u_keymatrix_scan (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .frame_end(frame_end),
    .key_ret(key_ret), .src_drive(src_drive), .rd_restart(rd_restart),
    .rd_adv(rd_adv), .rd_bit(rd_bit), .rd_byte(rd_byte)
  );

  always @(posedge clk) begin
    if (!rst_n) begin fcnt <= 0; frame_end <= 0; end
    else begin
      fcnt      <= (fcnt >= frame_len - 1) ? 0 : fcnt + 1;
      frame_end <= (fcnt >= frame_len - 1);
    end
  end

  always @(negedge clk) if (rst_n && $countones(src_drive) > 1) multi_hot++;

  // Stimulus {keys_b, keys_a} and expected 32-bit stream (R4).
  localparam logic [63:0] VEC [6] = '{
    {16'h0000, 16'h0001, 32'h0000_0001},
    {16'h8000, 16'h0000, 32'h8000_0000},
    {16'h0000, 16'hFFFF, 32'h5555_5555},
    {16'hFFFF, 16'h0000, 32'hAAAA_AAAA},
    {16'h0100, 16'h0011, 32'h0002_0101},
    {16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Serial read of the whole stream; optional stall after bit 15 (R7, R8).
  task automatic read_stream(input logic [31:0] exp, input string req,
                             input int stall, input logic [31:0] new_keys);
    logic [31:0] got;
    logic [31:0] gbytes;
    @(posedge clk); #1 rd_restart = 1;
    @(posedge clk); #1 rd_restart = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      got[i] = rd_bit;
      if (i % 8 == 0) gbytes[i +: 8] = rd_byte;
      if (i == 15 && stall > 0) begin
        keys_a = new_keys[15:0]; keys_b = new_keys[31:16];
        cyc(stall);
      end
      @(posedge clk); #1 rd_adv = 1;
      @(posedge clk); #1 rd_adv = 0;
    end
    check(got == exp, {req, " stream"}, got, exp);
    check(gbytes == exp, {req, " bytes"}, gbytes, exp);
  endtask

  initial begin
    int nz;
    cyc(3);
    // R1: reset state
    check(src_drive == 16'h0, "R1 drive", {16'h0, src_drive}, 32'h0);
    rst_n = 1;
    cyc(2);
    check(src_drive == 16'h0, "R1 drive idle", {16'h0, src_drive}, 32'h0);
    read_stream(32'h0, "R1", 0, 32'h0);

    // R2/R3: order and dwell of the source drive
    begin
      int idx = 0, len = 0;
      bit ok = 1;
      logic [15:0] prev = '0;
      scan_en = 1;
      repeat (400) begin
        @(negedge clk);
        if (src_drive !== prev) begin
          if (prev != 0) begin
            if (prev !== (16'h1 << (idx % 16)) || len != SLOT) ok = 0;
            idx++;
          end
          len = 0;
          prev = src_drive;
        end
        if (src_drive != 0) len++;
      end
      check(ok && idx >= 16, "R2 R3 order/dwell", idx, 16);
    end

    // R4: key bit placement, table walk
    for (int v = 0; v < 6; v++) begin
      keys_a = VEC[v][47:32];
      keys_b = VEC[v][63:48];
      cyc(6 * FRAME_OK);
      read_stream(VEC[v][31:0], "R4", 0, 32'h0);
    end

    // R5: frames too short never commit; buffer keeps 0xFFFFFFFF
    keys_a = 16'h0003; keys_b = 16'h0000;
    frame_len = FRAME_SHORT;
    cyc(12 * FRAME_SHORT);
    read_stream(32'hFFFF_FFFF, "R5 short frames", 0, 32'h0);
    frame_len = FRAME_OK;
    cyc(6 * FRAME_OK);
    read_stream(32'h0000_0005, "R5 full frames", 0, 32'h0);

    // R6: halted scan drives nothing and keeps the buffer
    keys_a = 16'h0000; keys_b = 16'h0400;
    scan_en = 0;
    nz = 0;
    cyc(1);
    repeat (200) begin @(negedge clk); if (src_drive != 0) nz++; end
    check(nz == 0, "R6 drive off", nz, 0);
    read_stream(32'h0000_0005, "R6 hold", 0, 32'h0);
    scan_en = 1;
    cyc(6 * FRAME_OK);
    read_stream(32'h0020_0000, "R6 resume", 0, 32'h0);

    // R8: commit during a read does not disturb it
    read_stream(32'h0020_0000, "R8 snapshot", 6 * FRAME_OK, {16'h0000, 16'h8000});
    read_stream(32'h4000_0000, "R8 after restart", 0, 32'h0);

    check(multi_hot == 0, "R2 one-hot", multi_hot, 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule